// File: doc/BRIEF.md
# Spectral Inversion Search Controller

This block owns the two I/Q exchange points of a QPSK receive path and finds out whether the transmitted spectrum is inverted. The first exchange point sits ahead of the demodulator. It is set statically from a configuration pin and corrects inversion caused by the receiver front-end. The second exchange point sits after the demodulator and is driven by a small search machine.

When software knows the transmit polarity, it programs it and the post-demodulation select holds that value. When the polarity is unknown, the machine waits for the carrier-lock flag. It then tries the straight setting for a programmable number of cycles while it watches the FEC-lock flag, and after that it tries the exchanged setting. If FEC lock appears, the winning setting is held and a done flag is raised. If neither setting locks, a failure flag is raised. Loss of carrier lock at any time sends the machine back to waiting.

Both exchange points are registered valid/ready stages on I/Q sample buses, with one cycle of latency. A stage accepts a sample when `*_in_valid` and `*_in_ready` are both high. `*_in_ready` is high whenever the stage holds nothing or its downstream is ready, so back-pressure reaches the source in the same cycle. A stalled output sample stays unchanged until it is taken.

Top module: `iqinv_ctrl`

## Requirements
- R1: `pre_swap` equals `cfg_fe_swap`. The pre stage outputs I=in_q, Q=in_i when it is 1, and I=in_i, Q=in_q when it is 0.
- R2: The post stage exchanges I and Q when `post_swap` is 1 and passes them straight through when it is 0. The select is sampled with each accepted sample.
- R3: A sample accepted at a clock edge appears on the stage output after that edge. `in_ready` = !out_valid || out_ready. While out_valid=1 and out_ready=0, the output sample and valid stay unchanged.
- R4: `tx_mode`=2'b01 (known straight) gives `post_swap`=0, and `tx_mode`=2'b10 (known inverted) gives `post_swap`=1. In both modes no search runs: busy, done and fail all stay 0.
- R5: `tx_mode`=2'b00 or 2'b11 means unknown polarity. The search starts only in the cycle after `carrier_lock` is seen high. Before that, `post_swap`=0 and busy=0.
- R6: The first trial uses `post_swap`=0 and lasts `trial_len` cycles, where a value of 0 counts as 1. The second trial then uses `post_swap`=1 and lasts the same length.
- R7: If `fec_lock` is high during a trial, the next cycle shows done=1, and `post_swap` holds the setting of that trial. This lasts until `fec_lock` or `carrier_lock` drops.
- R8: If both trials expire, fail=1 and `post_swap`=0. This holds while `carrier_lock` stays high. A new search starts only after `carrier_lock` drops and rises again.
- R9: If `carrier_lock` is low at an edge, then after that edge busy, done and fail are all 0 and `post_swap`=0 in the unknown modes.
- R10: At most one of busy, done and fail is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fe_swap | input | 1 | Front-end inversion correction, selects the pre-demodulation exchange |
| tx_mode | input | 2 | Transmit polarity: 00/11 unknown, 01 straight, 10 inverted |
| trial_len | input | CNT_W | Cycles per search trial (0 treated as 1) |
| carrier_lock | input | 1 | QPSK carrier lock flag |
| fec_lock | input | 1 | FEC lock flag |
| pre_in_valid | input | 1 | Pre stage input valid |
| pre_in_ready | output | 1 | Pre stage input ready |
| pre_in_i | input | DW | Pre stage input I |
| pre_in_q | input | DW | Pre stage input Q |
| pre_out_valid | output | 1 | Pre stage output valid |
| pre_out_ready | input | 1 | Pre stage output ready |
| pre_out_i | output | DW | Pre stage output I |
| pre_out_q | output | DW | Pre stage output Q |
| post_in_valid | input | 1 | Post stage input valid |
| post_in_ready | output | 1 | Post stage input ready |
| post_in_i | input | DW | Post stage input I |
| post_in_q | input | DW | Post stage input Q |
| post_out_valid | output | 1 | Post stage output valid |
| post_out_ready | input | 1 | Post stage output ready |
| post_out_i | output | DW | Post stage output I |
| post_out_q | output | DW | Post stage output Q |
| pre_swap | output | 1 | Current pre-demodulation exchange select |
| post_swap | output | 1 | Current post-demodulation exchange select |
| srch_busy | output | 1 | A trial is in progress |
| srch_done | output | 1 | FEC lock found, setting held |
| srch_fail | output | 1 | Both trials expired without FEC lock |

## Verification
The assertions assume that the lock flags and mode pins are synchronous to `clk` and free of X after reset. They also assume that a downstream holding `out_ready` low does not expect the stage to drop or alter its pending sample. The bench drives every input on the falling edge from tasks, keeps `tx_mode` and `trial_len` constant during each search scenario, and returns the machine to waiting between scenarios by clearing `carrier_lock`. Results are sampled on the falling edge, half a period after the edge that updates them.

// File: rtl/iqinv_pkg.sv
package iqinv_pkg;
  typedef enum logic [2:0] {
    S_WAIT = 3'd0,
    S_TRY0 = 3'd1,
    S_TRY1 = 3'd2,
    S_DONE = 3'd3,
    S_FAIL = 3'd4
  } srch_state_t;

  localparam logic [1:0] TX_UNKNOWN  = 2'b00;
  localparam logic [1:0] TX_STRAIGHT = 2'b01;
  localparam logic [1:0] TX_INVERTED = 2'b10;
endpackage

// File: rtl/iqswap_stage.sv
module iqswap_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= sel ? in_q : in_i;
        out_q <= sel ? in_i : in_q;
      end
    end
  end

  // R1 / R2: exchanged or straight sample according to the select at acceptance
  p_xchg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid &&
      out_i == ($past(sel) ? $past(in_q) : $past(in_i)) &&
      out_q == ($past(sel) ? $past(in_i) : $past(in_q)));

  // R3: a stalled sample is held unchanged
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_i) && $stable(out_q));
endmodule

// File: rtl/iqinv_search.sv
module iqinv_search
  import iqinv_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       tx_mode,
  input  logic [CNT_W-1:0] trial_len,
  input  logic             carrier_lock,
  input  logic             fec_lock,
  output logic             post_swap,
  output logic             busy,
  output logic             done,
  output logic             fail
);
  srch_state_t      state, state_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt, trial_last;
  logic             win, win_nxt, mode_known;

  assign trial_last = (trial_len == '0) ? '0 : trial_len - CNT_W'(1);
  assign mode_known = (tx_mode == TX_STRAIGHT) || (tx_mode == TX_INVERTED);

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    win_nxt   = win;
    if (mode_known || !carrier_lock) begin
      state_nxt = S_WAIT;
      cnt_nxt   = '0;
    end else begin
      unique case (state)
        S_WAIT: begin
          state_nxt = S_TRY0;
          cnt_nxt   = '0;
        end
        S_TRY0: begin
          if (fec_lock) begin
            state_nxt = S_DONE;
            win_nxt   = 1'b0;
          end else if (cnt == trial_last) begin
            state_nxt = S_TRY1;
            cnt_nxt   = '0;
          end else begin
            cnt_nxt = cnt + CNT_W'(1);
          end
        end
        S_TRY1: begin
          if (fec_lock) begin
            state_nxt = S_DONE;
            win_nxt   = 1'b1;
          end else if (cnt == trial_last) begin
            state_nxt = S_FAIL;
            cnt_nxt   = '0;
          end else begin
            cnt_nxt = cnt + CNT_W'(1);
          end
        end
        S_DONE: if (!fec_lock) state_nxt = S_WAIT;
        S_FAIL: state_nxt = S_FAIL;
        default: state_nxt = S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_WAIT;
      cnt   <= '0;
      win   <= 1'b0;
    end else begin
      state <= state_nxt;
      cnt   <= cnt_nxt;
      win   <= win_nxt;
    end
  end

  always_comb begin
    if (tx_mode == TX_INVERTED)      post_swap = 1'b1;
    else if (tx_mode == TX_STRAIGHT) post_swap = 1'b0;
    else post_swap = (state == S_TRY1) || (state == S_DONE && win);
  end

  assign busy = (state == S_TRY0) || (state == S_TRY1);
  assign done = (state == S_DONE);
  assign fail = (state == S_FAIL);

  // R9: carrier loss clears every status flag
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_lock |=> !(busy || done || fail));
  // R10: status flags never overlap
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done, fail}));
  // R4: known polarity runs no search
  p_known_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_known |=> !busy && !done && !fail);
  // R5: a search begins only after carrier lock was seen
  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(carrier_lock));
  // R6: the inverted trial is only ever entered from the straight trial
  p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TRY1 && $past(state) != S_TRY1) |-> $past(state) == S_TRY0);
  // R6: trial counter stays inside the programmed window
  p_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= trial_last);
endmodule

// File: rtl/iqinv_ctrl.sv
module iqinv_ctrl #(
  parameter int DW    = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fe_swap,
  input  logic [1:0]       tx_mode,
  input  logic [CNT_W-1:0] trial_len,
  input  logic             carrier_lock,
  input  logic             fec_lock,
  input  logic             pre_in_valid,
  output logic             pre_in_ready,
  input  logic [DW-1:0]    pre_in_i,
  input  logic [DW-1:0]    pre_in_q,
  output logic             pre_out_valid,
  input  logic             pre_out_ready,
  output logic [DW-1:0]    pre_out_i,
  output logic [DW-1:0]    pre_out_q,
  input  logic             post_in_valid,
  output logic             post_in_ready,
  input  logic [DW-1:0]    post_in_i,
  input  logic [DW-1:0]    post_in_q,
  output logic             post_out_valid,
  input  logic             post_out_ready,
  output logic [DW-1:0]    post_out_i,
  output logic [DW-1:0]    post_out_q,
  output logic             pre_swap,
  output logic             post_swap,
  output logic             srch_busy,
  output logic             srch_done,
  output logic             srch_fail
);
  assign pre_swap = cfg_fe_swap;

  iqinv_search #(.CNT_W(CNT_W)) u_search (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_mode      (tx_mode),
    .trial_len    (trial_len),
    .carrier_lock (carrier_lock),
    .fec_lock     (fec_lock),
    .post_swap    (post_swap),
    .busy         (srch_busy),
    .done         (srch_done),
    .fail         (srch_fail)
  );

  iqswap_stage #(.DW(DW)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (pre_swap),
    .in_valid  (pre_in_valid),
    .in_ready  (pre_in_ready),
    .in_i      (pre_in_i),
    .in_q      (pre_in_q),
    .out_valid (pre_out_valid),
    .out_ready (pre_out_ready),
    .out_i     (pre_out_i),
    .out_q     (pre_out_q)
  );

  iqswap_stage #(.DW(DW)) u_post (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (post_swap),
    .in_valid  (post_in_valid),
    .in_ready  (post_in_ready),
    .in_i      (post_in_i),
    .in_q      (post_in_q),
    .out_valid (post_out_valid),
    .out_ready (post_out_ready),
    .out_i     (post_out_i),
    .out_q     (post_out_q)
  );
endmodule

// File: tb/iqinv_ctrl_tb.sv
module iqinv_ctrl_tb;
  localparam int DW = 8;
  localparam int CNT_W = 16;
  localparam int T = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_fe_swap = 1'b0;
  logic [1:0] tx_mode = 2'b00;
  logic [CNT_W-1:0] trial_len = CNT_W'(T);
  logic carrier_lock = 1'b0, fec_lock = 1'b0;
  logic pre_in_valid = 1'b0, pre_out_ready = 1'b1;
  logic [DW-1:0] pre_in_i = '0, pre_in_q = '0;
  logic post_in_valid = 1'b0, post_out_ready = 1'b1;
  logic [DW-1:0] post_in_i = '0, post_in_q = '0;
  logic pre_in_ready, pre_out_valid, post_in_ready, post_out_valid;
  logic [DW-1:0] pre_out_i, pre_out_q, post_out_i, post_out_q;
  logic pre_swap, post_swap, srch_busy, srch_done, srch_fail;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  iqinv_ctrl #(.DW(DW), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fe_swap(cfg_fe_swap), .tx_mode(tx_mode),
    .trial_len(trial_len), .carrier_lock(carrier_lock), .fec_lock(fec_lock),
    .pre_in_valid(pre_in_valid), .pre_in_ready(pre_in_ready),
    .pre_in_i(pre_in_i), .pre_in_q(pre_in_q),
    .pre_out_valid(pre_out_valid), .pre_out_ready(pre_out_ready),
    .pre_out_i(pre_out_i), .pre_out_q(pre_out_q),
    .post_in_valid(post_in_valid), .post_in_ready(post_in_ready),
    .post_in_i(post_in_i), .post_in_q(post_in_q),
    .post_out_valid(post_out_valid), .post_out_ready(post_out_ready),
    .post_out_i(post_out_i), .post_out_q(post_out_q),
    .pre_swap(pre_swap), .post_swap(post_swap),
    .srch_busy(srch_busy), .srch_done(srch_done), .srch_fail(srch_fail)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // status packed as {busy,done,fail,post_swap}
  function automatic int st();
    return {srch_busy, srch_done, srch_fail, post_swap};
  endfunction

  task automatic settle();
    carrier_lock = 1'b0;
    fec_lock = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R9 reset status", st(), 0);
    check("R3 reset valid", {pre_out_valid, post_out_valid}, 0);
  endtask

  task automatic t_pre_swap();
    @(negedge clk);
    cfg_fe_swap = 1'b1;
    pre_in_valid = 1'b1; pre_in_i = 8'h11; pre_in_q = 8'h22;
    #0 check("R1 pre_swap follows cfg", pre_swap, 1);
    @(negedge clk);
    check("R1 swapped I", pre_out_i, 8'h22);
    check("R1 swapped Q", pre_out_q, 8'h11);
    cfg_fe_swap = 1'b0; pre_in_i = 8'h33; pre_in_q = 8'h44;
    @(negedge clk);
    check("R1 straight I/Q", {pre_out_i, pre_out_q}, 16'h3344);
    pre_in_valid = 1'b0;
    @(negedge clk);
    check("R3 valid drops", pre_out_valid, 0);
  endtask

  task automatic t_backpressure();
    pre_out_ready = 1'b0;
    pre_in_valid = 1'b1; pre_in_i = 8'hA1; pre_in_q = 8'hB2;
    @(negedge clk);
    check("R3 one-cycle latency", {pre_out_valid, pre_out_i}, {1'b1, 8'hA1});
    check("R3 ready low when stalled", pre_in_ready, 0);
    pre_in_i = 8'hC3; pre_in_q = 8'hD4;
    repeat (2) @(negedge clk);
    check("R3 held while stalled", {pre_out_i, pre_out_q}, 16'hA1B2);
    pre_out_ready = 1'b1;
    #0 check("R3 ready follows out_ready", pre_in_ready, 1);
    @(negedge clk);
    check("R3 next sample after release", {pre_out_i, pre_out_q}, 16'hC3D4);
    pre_in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_known();
    tx_mode = 2'b10; carrier_lock = 1'b1;
    post_in_valid = 1'b1; post_in_i = 8'h5A; post_in_q = 8'hA5;
    @(negedge clk);
    check("R4 inverted -> post_swap 1, idle", st(), 4'b0001);
    check("R2 post stage exchanged", {post_out_i, post_out_q}, 16'hA55A);
    post_in_valid = 1'b0;
    repeat (2 * T + 2) @(negedge clk);
    check("R4 no search while known", st(), 4'b0001);
    tx_mode = 2'b01;
    post_in_valid = 1'b1; post_in_i = 8'h12; post_in_q = 8'h34;
    @(negedge clk);
    check("R4 straight -> post_swap 0", st(), 4'b0000);
    check("R2 post stage straight", {post_out_i, post_out_q}, 16'h1234);
    post_in_valid = 1'b0;
    tx_mode = 2'b00;
    settle();
  endtask

  task automatic t_search_fail();
    repeat (3) @(negedge clk);
    check("R5 waits without carrier lock", st(), 0);
    carrier_lock = 1'b1;
    @(negedge clk);
    check("R5 search starts after lock", st(), 4'b1000);
    repeat (T - 1) @(negedge clk);
    check("R6 last cycle of straight trial", st(), 4'b1000);
    @(negedge clk);
    check("R6 second trial inverted", st(), 4'b1001);
    repeat (T - 1) @(negedge clk);
    check("R6 last cycle of inverted trial", st(), 4'b1001);
    @(negedge clk);
    check("R8 fail after both trials", st(), 4'b0010);
    repeat (5) @(negedge clk);
    check("R8 fail held while locked", st(), 4'b0010);
    carrier_lock = 1'b0;
    @(negedge clk);
    check("R9 fail cleared on lock loss", st(), 0);
    carrier_lock = 1'b1;
    @(negedge clk);
    check("R8 restart on new lock", st(), 4'b1000);
    settle();
  endtask

  task automatic t_lock_inverted();
    carrier_lock = 1'b1;
    repeat (T + 2) @(negedge clk);
    fec_lock = 1'b1;
    @(negedge clk);
    check("R7 done with swap 1", st(), 4'b0101);
    repeat (5) @(negedge clk);
    check("R7 swap 1 held", st(), 4'b0101);
    fec_lock = 1'b0;
    @(negedge clk);
    check("R7 done cleared on fec loss", st(), 0);
    @(negedge clk);
    check("R7 search restarts straight", st(), 4'b1000);
    settle();
  endtask

  task automatic t_lock_straight();
    carrier_lock = 1'b1; fec_lock = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 done with swap 0", st(), 4'b0100);
    carrier_lock = 1'b0;
    @(negedge clk);
    check("R9 done cleared on carrier loss", st(), 0);
    settle();
  endtask

  task automatic t_abort();
    carrier_lock = 1'b1;
    repeat (T + 1) @(negedge clk);
    check("R6 in inverted trial before abort", st(), 4'b1001);
    carrier_lock = 1'b0;
    @(negedge clk);
    check("R9 abort mid-search", st(), 0);
    settle();
  endtask

  task automatic t_zero_len();
    tx_mode = 2'b11; trial_len = '0;
    carrier_lock = 1'b1;
    @(negedge clk);
    check("R6 zero length straight trial", st(), 4'b1000);
    @(negedge clk);
    check("R6 zero length inverted trial", st(), 4'b1001);
    @(negedge clk);
    check("R8 zero length fail", st(), 4'b0010);
    trial_len = CNT_W'(T); tx_mode = 2'b00;
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_pre_swap();
    t_backpressure();
    t_known();
    t_search_fail();
    t_lock_inverted();
    t_lock_straight();
    t_abort();
    t_zero_len();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule